// File: doc/BRIEF.md
# Expansion ROM Window Register and Decoder

This block holds the configuration register that places an optional expansion ROM in the memory map of a PCI-style target, and it decides whether an incoming memory address falls inside that window. Configuration software reaches the register with dword reads and writes at byte offset 0x30 of a type 0 header (dword index 12). Each write carries four byte enables. The upper address bits that the window size allows are writable. Every bit below them, along with the reserved bits, reads as zero. Software can therefore write all ones, read the value back, and learn both the size and the alignment of the window.

On the decode side, the address comparator can be shared with one other base address window. While the ROM enable bit is set, the shared comparator serves only the ROM, and a flag tells the rest of the target that the other window is unavailable. A ROM hit requires both the command register's memory space bit and the ROM enable bit. The window size is a parameter, given as log2 of bytes. It is limited to the range 2 KB to 16 MB, and any value outside that range stops elaboration.

Top module: `xrom_window_decoder`

## Requirements
- R1: The register responds only when cfg_dw_addr equals 12. A write at any other index changes nothing. A read at any other index, and any cycle without cfg_rd, returns 0.
- R2: Bits 31 down to WIN_LOG2 store the ROM base and read back as written. Bits WIN_LOG2-1 down to 11 always read 0.
- R3: Writing 0xFFFFFFFE with all byte enables set and then reading returns ones in bits 31:WIN_LOG2 and zeros elsewhere. For WIN_LOG2 = 13 this value is 0xFFFFE000.
- R4: Bits 10:1 are reserved. They read 0 whatever value was written to them.
- R5: Byte enable k (bits 8k+7:8k) gates the update of the stored bits in that lane. In lane 0, only bit 0 (the enable) can change.
- R6: While rst_n is low at a clock edge, both the enable bit and the base are cleared. A read afterwards returns 0.
- R7: With the enable bit set and mem_space_en high, rom_hit is 1 exactly when mem_addr[31:WIN_LOG2] equals the stored base. Bits below WIN_LOG2 are the offset within the window.
- R8: When mem_space_en is 0, rom_hit is 0 regardless of the enable bit. When the enable bit is 0, rom_hit is 0 regardless of the address.
- R9: With the shared comparator, rom_owns_decoder equals the enable bit, and alt_hit stays 0 while the enable bit is 1.
- R10: With the shared comparator and the enable bit 0, alt_hit is 1 exactly when mem_space_en is 1 and mem_addr[31:WIN_LOG2] equals alt_base[31:WIN_LOG2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational, 0 when not selected |
| mem_space_en | input | 1 | Memory space bit from the command register |
| mem_addr | input | 32 | Memory address to decode |
| alt_base | input | 32 | Base of the other window that shares the comparator |
| rom_hit | output | 1 | Address falls in the enabled ROM window |
| alt_hit | output | 1 | Address falls in the other window |
| rom_owns_decoder | output | 1 | Shared comparator is reserved for the ROM |

## Verification
The bench builds the block with WIN_LOG2 = 13 (an 8 KB window) and with the shared comparator. With this size, byte lane 1 is only partly writable (bits 15:13 stored, bits 12:11 forced to zero), so the byte-enable and sizing checks cover a lane that mixes stored and hardwired bits. Sharing the comparator lets the bench observe the handover between the ROM window and the other window as the enable bit toggles. The bench also checks window edges one byte inside and one byte outside the programmed base.

// File: rtl/xrom_pkg.sv
// Package xrom_pkg
// Constants shared by the expansion ROM window register and its decoder.
// Assumes a 32-bit configuration dword and a 32-bit memory address.
package xrom_pkg;
    localparam int XROM_DW       = 32;
    localparam int XROM_ADDR_LSB = 11;        // lowest base address bit of the register
    localparam int XROM_MAX_LOG2 = 24;        // largest window: 16 MB
    localparam int XROM_LANES    = XROM_DW / 8;
    localparam logic [5:0] XROM_DW_INDEX = 6'd12;   // byte offset 0x30

    // Mask with ones in the bits a window of 2**log2 bytes can store.
    function automatic logic [XROM_DW-1:0] xrom_base_mask(input int log2);
        return {XROM_DW{1'b1}} << log2;
    endfunction
endpackage

// File: rtl/xrom_cfg_reg.sv
// Module xrom_cfg_reg
// Holds the writable part of the expansion ROM register: the enable flag and
// the upper base address bits. Each bit updates only when its byte lane is
// enabled. Assumes wr_sel is already qualified by the register index.
module xrom_cfg_reg
    import xrom_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    localparam int BASE_W  = XROM_DW - WIN_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  logic [XROM_LANES-1:0] be,
    input  logic [XROM_DW-1:0]   wdata,
    output logic                 en_q,
    output logic [BASE_W-1:0]    base_q
);
    // Bits below the base field are reserved or hardwired and never stored.
    logic unused_wdata_low;
    assign unused_wdata_low = ^wdata[WIN_LOG2-1:1];

    // Enable flag: cleared by reset, written only through byte lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_sel && be[0]) begin
            en_q <= wdata[0];
        end
    end

    // Base bits: one flop per stored bit, gated by the lane that carries it.
    for (genvar i = 0; i < BASE_W; i++) begin : g_base_bit
        localparam int BIT_POS = i + WIN_LOG2;
        localparam int LANE    = BIT_POS / 8;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= 1'b0;
            end else if (wr_sel && be[LANE]) begin
                base_q[i] <= wdata[BIT_POS];
            end
        end
    end

    // R1: without a selected write, the stored state does not move.
    assert_idle_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> ($stable(en_q) && $stable(base_q)));

    // R5: the top byte lane holds when its enable is low.
    assert_lane3_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !be[3]) |=> $stable(base_q[BASE_W-1 -: 8]));

    // R6: the first cycle after reset sees a cleared register.
    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!en_q && base_q == '0));
endmodule

// File: rtl/xrom_readback.sv
// Module xrom_readback
// Builds the configuration read image from the stored fields. Hardwired base
// bits and reserved bits read as zero, which gives software its sizing value.
// Assumes rd_sel is already qualified by the register index.
module xrom_readback
    import xrom_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    localparam int BASE_W  = XROM_DW - WIN_LOG2
) (
    input  logic              rd_sel,
    input  logic              en_q,
    input  logic [BASE_W-1:0] base_q,
    output logic [XROM_DW-1:0] rdata
);
    logic [XROM_DW-1:0] image;

    // Place the base at its bit position and the enable in bit 0.
    always_comb begin
        image    = {base_q, {WIN_LOG2{1'b0}}};
        image[0] = en_q;
    end

    // Return the image only for a selected read, otherwise zero.
    always_comb begin
        rdata = rd_sel ? image : '0;
    end
endmodule

// File: rtl/xrom_match.sv
// Module xrom_match
// Compares a memory address with the ROM base and with the base of the other
// window. SHARE_DECODER = 1 uses one comparator that the ROM claims while it
// is enabled. SHARE_DECODER = 0 gives each window its own comparator.
// Assumes both windows have the same size, 2**WIN_LOG2 bytes.
module xrom_match
    import xrom_pkg::*;
#(
    parameter int WIN_LOG2      = 16,
    parameter bit SHARE_DECODER = 1'b1,
    localparam int BASE_W       = XROM_DW - WIN_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_space_en,
    input  logic [XROM_DW-1:0] mem_addr,
    input  logic [XROM_DW-1:0] alt_base,
    input  logic               rom_en,
    input  logic [BASE_W-1:0]  rom_base,
    output logic               rom_hit,
    output logic               alt_hit,
    output logic               rom_owns
);
    logic [BASE_W-1:0] addr_hi;
    logic [BASE_W-1:0] alt_hi;
    logic unused_low_bits;

    // Split off the window offset; only the upper bits take part in a match.
    assign addr_hi = mem_addr[XROM_DW-1:WIN_LOG2];
    assign alt_hi  = alt_base[XROM_DW-1:WIN_LOG2];
    assign unused_low_bits = ^{mem_addr[WIN_LOG2-1:0], alt_base[WIN_LOG2-1:0]};

    if (SHARE_DECODER) begin : g_shared
        logic [BASE_W-1:0] cmp_base;
        logic              same;

        // Steer the single comparator to whichever window owns it.
        always_comb begin
            cmp_base = rom_en ? rom_base : alt_hi;
            same     = (addr_hi == cmp_base);
        end

        // Qualify the match with memory space and ownership.
        always_comb begin
            rom_hit  = mem_space_en && rom_en && same;
            alt_hit  = mem_space_en && !rom_en && same;
            rom_owns = rom_en;
        end

        // R9: both windows never claim the same address.
        assert_one_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(rom_hit && alt_hit));
    end else begin : g_split
        logic rom_same;
        logic alt_same;

        // Two comparators, one per window.
        always_comb begin
            rom_same = (addr_hi == rom_base);
            alt_same = (addr_hi == alt_hi);
        end

        // Each window decodes on its own; the ROM never takes the other's comparator.
        always_comb begin
            rom_hit  = mem_space_en && rom_en && rom_same;
            alt_hit  = mem_space_en && alt_same;
            rom_owns = 1'b0;
        end
    end
endmodule

// File: rtl/xrom_window_decoder.sv
// Module xrom_window_decoder
// Top level of the expansion ROM window: decodes configuration accesses to
// dword index 12, keeps the register, builds the read image and decodes
// memory addresses. Assumes one configuration access per cycle and a window
// between 2 KB and 16 MB.
module xrom_window_decoder
    import xrom_pkg::*;
#(
    parameter int WIN_LOG2      = 16,
    parameter bit SHARE_DECODER = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_space_en,
    input  logic [31:0] mem_addr,
    input  logic [31:0] alt_base,
    output logic        rom_hit,
    output logic        alt_hit,
    output logic        rom_owns_decoder
);
    localparam int BASE_W = XROM_DW - WIN_LOG2;

    if (WIN_LOG2 < XROM_ADDR_LSB || WIN_LOG2 > XROM_MAX_LOG2) begin : g_bad_size
        $error("xrom_window_decoder: WIN_LOG2 must lie in 11..24");
    end

    logic              reg_sel;
    logic              wr_sel;
    logic              rd_sel;
    logic              en_q;
    logic [BASE_W-1:0] base_q;

    // Qualify both strobes with the register index.
    always_comb begin
        reg_sel = (cfg_dw_addr == XROM_DW_INDEX);
        wr_sel  = cfg_wr && reg_sel;
        rd_sel  = cfg_rd && reg_sel;
    end

    xrom_cfg_reg #(.WIN_LOG2(WIN_LOG2)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .en_q   (en_q),
        .base_q (base_q)
    );

    xrom_readback #(.WIN_LOG2(WIN_LOG2)) u_rb (
        .rd_sel (rd_sel),
        .en_q   (en_q),
        .base_q (base_q),
        .rdata  (cfg_rdata)
    );

    xrom_match #(.WIN_LOG2(WIN_LOG2), .SHARE_DECODER(SHARE_DECODER)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_space_en (mem_space_en),
        .mem_addr     (mem_addr),
        .alt_base     (alt_base),
        .rom_en       (en_q),
        .rom_base     (base_q),
        .rom_hit      (rom_hit),
        .alt_hit      (alt_hit),
        .rom_owns     (rom_owns_decoder)
    );

    // R8: a ROM hit needs the memory space bit.
    assert_hit_needs_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_hit |-> mem_space_en);

    // R7: a ROM hit lies inside the window that a selected read reports.
    assert_hit_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_hit && rd_sel) |-> (cfg_rdata[0] &&
            cfg_rdata[31:WIN_LOG2] == mem_addr[31:WIN_LOG2]));
endmodule

// File: tb/sim_xrom_window_decoder.sv
module sim_xrom_window_decoder;
    localparam int W = 13;
    localparam logic [31:0] MASK = 32'hFFFF_FFFF << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [5:0] cfg_dw_addr = 6'd0;
    logic [3:0] cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic mem_space_en = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic [31:0] alt_base = 32'h0;
    logic rom_hit, alt_hit, rom_owns_decoder;

    int total = 0, bad = 0;
    bit started = 0, done = 0;
    string cur = "R6";

    logic [31:0] m_base = 32'h0;
    bit m_en = 0;

    always #4 clk = ~clk;

    xrom_window_decoder #(.WIN_LOG2(W), .SHARE_DECODER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_space_en(mem_space_en), .mem_addr(mem_addr),
        .alt_base(alt_base), .rom_hit(rom_hit), .alt_hit(alt_hit),
        .rom_owns_decoder(rom_owns_decoder)
    );

    // Behavioural reference: register state updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 32'h0;
            m_en = 0;
            started = 1;
        end else if (cfg_wr && cfg_dw_addr == 6'd12) begin
            for (int l = 0; l < 4; l++)
                if (cfg_be[l]) m_base = (m_base & ~(32'hFF << (8*l))) | (cfg_wdata & (32'hFF << (8*l)));
            m_base = m_base & MASK;
            if (cfg_be[0]) m_en = cfg_wdata[0];
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] e_rd;
            e_rd = (cfg_rd && cfg_dw_addr == 6'd12) ? (m_base | {31'h0, m_en}) : 32'h0;
            chk({cur, " rdata"}, cfg_rdata, e_rd);
            chk({cur, " rom_hit"}, {31'h0, rom_hit},
                {31'h0, mem_space_en && m_en && ((mem_addr & MASK) == m_base)});
            chk({cur, " alt_hit"}, {31'h0, alt_hit},
                {31'h0, mem_space_en && !m_en && ((mem_addr & MASK) == (alt_base & MASK))});
            chk({cur, " owns"}, {31'h0, rom_owns_decoder}, {31'h0, m_en});
        end
    end

    task automatic cfg_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 0; cfg_be = 4'h0;
    endtask

    // Present a read for one cycle and check its data mid-cycle.
    task automatic cfg_read(logic [5:0] a, string req, logic [31:0] exp);
        @(posedge clk); #1;
        cfg_rd = 1; cfg_dw_addr = a;
        #2;
        chk(req, cfg_rdata, exp);
        @(posedge clk); #1;
        cfg_rd = 0;
    endtask

    task automatic probe(bit ms, logic [31:0] a, string req, bit exp_rom, bit exp_alt);
        @(posedge clk); #1;
        mem_space_en = ms; mem_addr = a;
        #2;
        chk({req, " rom_hit"}, {31'h0, rom_hit}, {31'h0, exp_rom});
        chk({req, " alt_hit"}, {31'h0, alt_hit}, {31'h0, exp_alt});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur = "R6"; cfg_read(6'd12, "R6 reset value", 32'h0);
        chk("R6 owns after reset", {31'h0, rom_owns_decoder}, 32'h0);

        cur = "R3"; cfg_write(6'd12, 4'hF, 32'hFFFF_FFFE);
        cfg_read(6'd12, "R3 sizing readback", 32'hFFFF_E000);

        cur = "R4"; cfg_write(6'd12, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd12, "R4 reserved bits zero", 32'hFFFF_E001);

        cur = "R1"; cfg_write(6'd13, 4'hF, 32'h0);
        cfg_read(6'd12, "R1 other index write ignored", 32'hFFFF_E001);
        cfg_read(6'd13, "R1 other index reads zero", 32'h0);

        cur = "R5"; cfg_write(6'd12, 4'h1, 32'h0);
        cfg_read(6'd12, "R5 lane0 only enable", 32'hFFFF_E000);
        cfg_write(6'd12, 4'h8, 32'h1200_0000);
        cfg_read(6'd12, "R5 lane3 only", 32'h12FF_E000);
        cfg_write(6'd12, 4'h2, 32'h0000_4000);
        cfg_read(6'd12, "R5 lane1 partial", 32'h12FF_4000);

        cur = "R2"; cfg_write(6'd12, 4'hF, 32'hABCD_5F01);
        cfg_read(6'd12, "R2 base stored", 32'hABCD_4001);

        cur = "R7";
        probe(1, 32'hABCD_4000, "R7 window start", 1, 0);
        probe(1, 32'hABCD_5FFF, "R7 window end", 1, 0);
        probe(1, 32'hABCD_6000, "R7 above window", 0, 0);
        probe(1, 32'hABCD_3FFF, "R7 below window", 0, 0);

        cur = "R8";
        probe(0, 32'hABCD_4000, "R8 memory space off", 0, 0);

        cur = "R9"; alt_base = 32'h1111_0000;
        probe(1, 32'h1111_0010, "R9 alt blocked", 0, 0);
        chk("R9 owns", {31'h0, rom_owns_decoder}, 32'h1);

        cur = "R10"; cfg_write(6'd12, 4'h1, 32'h0);
        probe(1, 32'h1111_0010, "R10 alt hit", 0, 1);
        probe(1, 32'hABCD_4000, "R8 rom disabled", 0, 0);
        probe(0, 32'h1111_0010, "R10 alt needs mem space", 0, 0);

        cur = "R6"; cfg_write(6'd12, 4'hF, 32'h5555_A001);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        cfg_read(6'd12, "R6 mid-run reset", 32'h0);
        chk("R6 owns cleared", {31'h0, rom_owns_decoder}, 32'h0);

        repeat (2) @(posedge clk);
        #2 finish_run();
    end
endmodule